// File: doc/BRIEF.md
# Fully Associative Read Cache with Rotating Victim Pointer

This block is a small read-only cache in which any memory block may sit in any of its entries. Each entry keeps a valid flag, a tag and one whole block. An incoming address is compared against every stored tag at once. A hit answers in the same cycle with the addressed word of the block. A miss asks a memory port for the whole block, writes it into one entry and then answers the request.

The victim entry is chosen by one rotating pointer rather than by full least-recently-used tracking. Filling the entry under the pointer advances it. A hit on the entry under the pointer also advances it, so the pointer tends to move away from entries in active use. A hit on any other entry leaves the pointer where it is.

A requester raises `rd_req` with an address and holds both until `rd_ready` is seen high at a clock edge. The memory side sees `fill_req` with the block's tag and answers with a one-cycle `fill_valid` pulse that carries the whole block.

Top module: `fac_cache`

## Requirements
- R1: After reset no entry is valid: `rd_ready` and `fill_req` are low, and the first request to any address misses.
- R2: Address bits 31:5 form the tag and bits 4:0 the byte offset. Two addresses that differ only in bits 4:0 share one block. `rd_data` is word `addr[4:2]` of the block, and word w sits at `fill_block[32*w+31 : 32*w]`.
- R3: A request whose tag matches a valid entry raises `rd_ready` in the same cycle with the correct data, and no fill is started.
- R4: A request that misses raises `fill_req` in the next cycle with `fill_addr` equal to address bits 31:5. Both stay unchanged until `fill_valid`, and `rd_ready` stays low meanwhile.
- R5: In the cycle after `fill_valid` is accepted, the held request is answered with `rd_ready` high and data taken from the delivered block.
- R6: A miss writes the new block into the entry under the pointer, and the pointer then moves to the next entry. It wraps from the last entry back to entry 0, so once every entry has been filled, the next new block evicts the first block that was filled.
- R7: A hit on the entry under the pointer moves the pointer to the next entry, so the next victim is the entry after it.
- R8: A hit on any entry other than the one under the pointer leaves the pointer unchanged.
- R9: At most one valid entry matches any tag.
- R10: All 64 entries can hold blocks at the same time. After 64 distinct blocks are filled from reset, every one of them hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rd_req | input | 1 | Read request, held until accepted |
| rd_addr | input | 32 | Byte address of the read |
| rd_ready | output | 1 | Request answered this cycle |
| rd_data | output | 32 | Addressed word of the hitting block |
| fill_req | output | 1 | Block fetch request to memory |
| fill_addr | output | 27 | Tag of the block to fetch |
| fill_valid | input | 1 | Fetched block is present on `fill_block` |
| fill_block | input | 256 | Whole block returned by memory |

## Verification
The checker tests several rules on every cycle. At most one entry matches any tag. `rd_ready` never appears without a request or during a fill. A pending fill holds its request and address. The pointer moves by exactly one (with wrap) when its own entry is touched, and otherwise stays put. Whether the right block gets evicted can only be seen across a sequence of requests, so directed scenarios show it. They fill every entry, make selective hits on and off the pointer, and then check which earlier blocks miss. The scenarios also check the word selection and the fill handshake at the ports.

// File: rtl/fac_pkg.sv
package fac_pkg;

   typedef enum logic [0:0] {
      ST_LOOKUP = 1'b0,
      ST_FILL   = 1'b1
   } fac_state_e;

endpackage

// File: rtl/fac_tag_match.sv
module fac_tag_match #(
   parameter int ENTRIES = 64,
   parameter int TAG_W   = 27,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic [TAG_W-1:0]         look_tag,
   input  logic [ENTRIES-1:0]       valid_vec,
   input  logic [ENTRIES*TAG_W-1:0] tag_flat,
   output logic [ENTRIES-1:0]       match_vec,
   output logic                     any_hit,
   output logic [IDX_W-1:0]         hit_idx
);

   for (genvar e = 0; e < ENTRIES; e++) begin : g_cmp
      assign match_vec[e] = valid_vec[e] &&
                            (tag_flat[e*TAG_W +: TAG_W] == look_tag);
   end

   assign any_hit = |match_vec;

   always_comb begin
      hit_idx = '0;
      for (int e = 0; e < ENTRIES; e++) begin
         if (match_vec[e]) hit_idx = hit_idx | IDX_W'(e);
      end
   end

endmodule

// File: rtl/fac_line_store.sv
module fac_line_store #(
   parameter int ENTRIES = 64,
   parameter int TAG_W   = 27,
   parameter int BLK_W   = 256,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic                     clk,
   input  logic                     rst_n,
   input  logic                     wr_en,
   input  logic [IDX_W-1:0]         wr_idx,
   input  logic [TAG_W-1:0]         wr_tag,
   input  logic [BLK_W-1:0]         wr_block,
   input  logic [IDX_W-1:0]         rd_idx,
   output logic [ENTRIES-1:0]       valid_vec,
   output logic [ENTRIES*TAG_W-1:0] tag_flat,
   output logic [BLK_W-1:0]         rd_block
);

   logic [BLK_W-1:0] blk_q [ENTRIES];

   for (genvar e = 0; e < ENTRIES; e++) begin : g_ent
      logic hit_wr;
      assign hit_wr = wr_en && (wr_idx == IDX_W'(e));

      always_ff @(posedge clk) begin
         if (!rst_n)      valid_vec[e] <= 1'b0;
         else if (hit_wr) valid_vec[e] <= 1'b1;
      end

      always_ff @(posedge clk) begin
         if (hit_wr) begin
            tag_flat[e*TAG_W +: TAG_W] <= wr_tag;
            blk_q[e]                   <= wr_block;
         end
      end
   end

   assign rd_block = blk_q[rd_idx];

endmodule

// File: rtl/fac_repl_ptr.sv
module fac_repl_ptr #(
   parameter int ENTRIES = 64,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             touch_en,
   input  logic [IDX_W-1:0] touch_idx,
   output logic [IDX_W-1:0] ptr
);

   localparam logic [IDX_W-1:0] LAST = IDX_W'(ENTRIES - 1);

   logic [IDX_W-1:0] ptr_inc;

   if ((1 << IDX_W) == ENTRIES) begin : g_pow2
      assign ptr_inc = ptr + 1'b1;
   end else begin : g_wrap
      assign ptr_inc = (ptr == LAST) ? '0 : ptr + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)
         ptr <= '0;
      else if (touch_en && (touch_idx == ptr))
         ptr <= ptr_inc;
   end

endmodule

// File: rtl/fac_cache.sv
module fac_cache #(
   parameter int ADDR_W  = 32,
   parameter int OFFS_W  = 5,
   parameter int ENTRIES = 64,
   parameter int WORD_W  = 32
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          rd_req,
   input  logic [ADDR_W-1:0]             rd_addr,
   output logic                          rd_ready,
   output logic [WORD_W-1:0]             rd_data,
   output logic                          fill_req,
   output logic [ADDR_W-OFFS_W-1:0]      fill_addr,
   input  logic                          fill_valid,
   input  logic [8*(1<<OFFS_W)-1:0]      fill_block
);
   import fac_pkg::*;

   localparam int TAG_W  = ADDR_W - OFFS_W;
   localparam int BLK_W  = 8 * (1 << OFFS_W);
   localparam int IDX_W  = $clog2(ENTRIES);
   localparam int BSEL_W = $clog2(WORD_W / 8);
   localparam int WSEL_W = OFFS_W - BSEL_W;

   if (ENTRIES < 2) begin : g_chk_ent
      $error("fac_cache: ENTRIES must be at least 2");
   end
   if (WORD_W % 8 != 0 || WORD_W > BLK_W) begin : g_chk_word
      $error("fac_cache: WORD_W must be whole bytes and fit in a block");
   end
   if (TAG_W < 1) begin : g_chk_tag
      $error("fac_cache: OFFS_W leaves no tag bits");
   end

   fac_state_e             state_q;
   logic [TAG_W-1:0]       look_tag;
   logic [TAG_W-1:0]       miss_tag_q;
   logic [ENTRIES-1:0]     valid_vec;
   logic [ENTRIES*TAG_W-1:0] tag_flat;
   logic [ENTRIES-1:0]     match_vec;
   logic                   any_hit;
   logic [IDX_W-1:0]       hit_idx;
   logic [IDX_W-1:0]       ptr;
   logic                   fill_done;
   logic                   touch_en;
   logic [IDX_W-1:0]       touch_idx;
   logic [BLK_W-1:0]       rd_block;

   assign look_tag  = rd_addr[ADDR_W-1:OFFS_W];
   assign rd_ready  = (state_q == ST_LOOKUP) && rd_req && any_hit;
   assign fill_req  = (state_q == ST_FILL);
   assign fill_addr = miss_tag_q;
   assign fill_done = fill_req && fill_valid;
   assign touch_en  = rd_ready || fill_done;
   assign touch_idx = fill_done ? ptr : hit_idx;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_LOOKUP;
      end else begin
         case (state_q)
            ST_LOOKUP: if (rd_req && !any_hit) state_q <= ST_FILL;
            ST_FILL:   if (fill_valid)         state_q <= ST_LOOKUP;
            default:                           state_q <= ST_LOOKUP;
         endcase
      end
   end

   always_ff @(posedge clk) begin
      if (state_q == ST_LOOKUP && rd_req && !any_hit) miss_tag_q <= look_tag;
   end

   fac_tag_match #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) u_match (
      .look_tag (look_tag),
      .valid_vec(valid_vec),
      .tag_flat (tag_flat),
      .match_vec(match_vec),
      .any_hit  (any_hit),
      .hit_idx  (hit_idx)
   );

   fac_line_store #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .BLK_W(BLK_W)) u_store (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (fill_done),
      .wr_idx   (ptr),
      .wr_tag   (miss_tag_q),
      .wr_block (fill_block),
      .rd_idx   (hit_idx),
      .valid_vec(valid_vec),
      .tag_flat (tag_flat),
      .rd_block (rd_block)
   );

   fac_repl_ptr #(.ENTRIES(ENTRIES)) u_ptr (
      .clk      (clk),
      .rst_n    (rst_n),
      .touch_en (touch_en),
      .touch_idx(touch_idx),
      .ptr      (ptr)
   );

   if (WSEL_W > 0) begin : g_wsel
      logic [WSEL_W-1:0] wsel;
      assign wsel    = rd_addr[OFFS_W-1:BSEL_W];
      assign rd_data = rd_block[wsel*WORD_W +: WORD_W];
   end else begin : g_whole
      assign rd_data = rd_block[WORD_W-1:0];
   end

endmodule

// File: rtl/fac_cache_chk.sv
module fac_cache_chk #(
   parameter int ENTRIES = 64,
   parameter int TAG_W   = 27,
   localparam int IDX_W  = $clog2(ENTRIES)
) (
   input logic               clk,
   input logic               rst_n,
   input logic               rd_req,
   input logic               rd_ready,
   input logic               fill_req,
   input logic               fill_valid,
   input logic [TAG_W-1:0]   fill_addr,
   input logic [ENTRIES-1:0] match_vec,
   input logic [IDX_W-1:0]   ptr,
   input logic               touch_en,
   input logic [IDX_W-1:0]   touch_idx
);

   a_r9_single_match: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(match_vec));

   a_r3_ready_needs_req: assert property (@(posedge clk) disable iff (!rst_n)
      rd_ready |-> rd_req);

   a_r4_no_ready_in_fill: assert property (@(posedge clk) disable iff (!rst_n)
      fill_req |-> !rd_ready);

   a_r4_fill_held: assert property (@(posedge clk) disable iff (!rst_n)
      (fill_req && !fill_valid) |=> (fill_req && $stable(fill_addr)));

   a_r8_ptr_hold: assert property (@(posedge clk) disable iff (!rst_n)
      !(touch_en && (touch_idx == ptr)) |=> $stable(ptr));

   a_r6_ptr_step: assert property (@(posedge clk) disable iff (!rst_n)
      (touch_en && (touch_idx == ptr)) |=>
         (ptr == (($past(ptr) == IDX_W'(ENTRIES - 1)) ? '0 : $past(ptr) + 1'b1)));

endmodule

bind fac_cache fac_cache_chk #(.ENTRIES(ENTRIES), .TAG_W(TAG_W)) chk_i (
   .clk       (clk),
   .rst_n     (rst_n),
   .rd_req    (rd_req),
   .rd_ready  (rd_ready),
   .fill_req  (fill_req),
   .fill_valid(fill_valid),
   .fill_addr (fill_addr),
   .match_vec (match_vec),
   .ptr       (ptr),
   .touch_en  (touch_en),
   .touch_idx (touch_idx)
);

// File: tb/fac_cache_tb_top.sv
module fac_cache_tb_top;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic         rd_req = 1'b0;
   logic [31:0]  rd_addr = '0;
   logic         rd_ready;
   logic [31:0]  rd_data;
   logic         fill_req;
   logic [26:0]  fill_addr;
   logic         fill_valid = 1'b0;
   logic [255:0] fill_block = '0;

   int n_run = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #5 clk = ~clk;

   fac_cache dut_i (
      .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .rd_addr(rd_addr),
      .rd_ready(rd_ready), .rd_data(rd_data), .fill_req(fill_req),
      .fill_addr(fill_addr), .fill_valid(fill_valid), .fill_block(fill_block)
   );

   function automatic logic [31:0] word_of(input logic [26:0] tag, input int w);
      return {tag, 3'(w), 2'b01};
   endfunction

   function automatic logic [255:0] block_of(input logic [26:0] tag);
      logic [255:0] b;
      for (int w = 0; w < 8; w++) b[32*w +: 32] = word_of(tag, w);
      return b;
   endfunction

   function automatic logic [31:0] a_addr(input int i);
      return 32'h4000_0000 + 32'(i) * 32'h0001_0020;
   endfunction

   function automatic logic [31:0] b_addr(input int i);
      return 32'h8000_0000 + 32'(i) * 32'h20;
   endfunction

   task automatic chk(input bit ok, input string req, input logic [63:0] act,
                      input logic [63:0] exp);
      n_run++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // One request; exp_hit says whether it should be answered without a fill.
   task automatic do_read(input logic [31:0] addr, input bit exp_hit, input string req);
      bit got_hit;
      @(negedge clk);
      rd_req = 1'b1;
      rd_addr = addr;
      #1;
      got_hit = rd_ready;
      chk(got_hit == exp_hit, req, 64'(got_hit), 64'(exp_hit));
      if (!got_hit) begin
         @(posedge clk); #1;
         chk(fill_req === 1'b1 && fill_addr === addr[31:5], "R4 fill request",
             {fill_req, 27'(fill_addr)}, {1'b1, addr[31:5]});
         @(posedge clk); #1;
         chk(fill_req === 1'b1 && rd_ready === 1'b0 && fill_addr === addr[31:5],
             "R4 hold while waiting", {fill_req, rd_ready}, 64'b10);
         fill_valid = 1'b1;
         fill_block = block_of(addr[31:5]);
         @(posedge clk); #1;
         fill_valid = 1'b0;
         fill_block = '0;
         chk(rd_ready === 1'b1, "R5 ready after fill", 64'(rd_ready), 64'd1);
      end
      chk(rd_data === word_of(addr[31:5], int'(addr[4:2])), "R2 word select",
          64'(rd_data), 64'(word_of(addr[31:5], int'(addr[4:2]))));
      @(posedge clk); #1;
      rd_req = 1'b0;
   endtask

   task automatic t_reset();
      repeat (3) @(posedge clk);
      #1;
      chk(rd_ready === 1'b0 && fill_req === 1'b0, "R1 outputs in reset",
          {rd_ready, fill_req}, 64'd0);
      rst_n = 1'b1;
      do_read(a_addr(0), 1'b0, "R1 first access misses");
   endtask

   task automatic t_offsets();
      // Entry 0 holds A0, pointer at 1: same block, other words, must hit.
      do_read(a_addr(0) + 32'd4, 1'b1, "R2 same block word 1 hits");
      do_read(a_addr(0) + 32'd29, 1'b1, "R3 same block word 7 hits");
   endtask

   task automatic t_fill_all();
      for (int i = 1; i < 64; i++) do_read(a_addr(i) + 32'(4 * (i % 8)), 1'b0, "R6 fill entry");
      // Pointer now wrapped to 0; sweep hits entries 0..63 in order.
      for (int i = 0; i < 64; i++) do_read(a_addr(i), 1'b1, "R10 all resident");
   endtask

   task automatic t_pointer();
      do_read(a_addr(5), 1'b1, "R8 off-pointer hit");      // ptr stays 0
      do_read(b_addr(0), 1'b0, "R6 miss evicts ptr 0");    // A0 out, ptr 1
      do_read(a_addr(1), 1'b1, "R7 hit on pointer entry"); // ptr 2
      do_read(b_addr(1), 1'b0, "R6 second miss");          // A2 out, ptr 3
      do_read(b_addr(0), 1'b1, "R8 B0 resident");
      do_read(b_addr(1), 1'b1, "R8 B1 resident");
      do_read(a_addr(5), 1'b1, "R8 A5 survived");
      do_read(a_addr(1), 1'b1, "R7 A1 survived after pointer moved");
      do_read(a_addr(0), 1'b0, "R6 A0 was victim");        // A3 out, ptr 4
      do_read(a_addr(2), 1'b0, "R7 A2 was victim");        // A4 out, ptr 5
      do_read(a_addr(3), 1'b0, "R8 A3 evicted after hold");
   endtask

   initial begin
      t_reset();
      t_offsets();
      t_fill_all();
      t_pointer();
      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         n_run++;
         n_fail++;
         $display("FAIL watchdog actual=timeout expected=completion");
         $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
         $finish;
      end
   end

endmodule